// File: doc/BRIEF.md
# Fault Reaction Delay Timer

This block sets how long a protection fault has to persist before the protection logic acts on it. It has two independent channels. The over-current channel uses a 6-bit delay code and counts in coarse ticks. The short-circuit channel uses a 7-bit delay code and counts in ticks eight times finer. Each channel has a fault input, a counter and a latched trip output. The counters and trips run on a slow low-power clock. The two delay codes are written and read back on the CPU clock.

A written code is copied into the slow domain with a toggle request and a toggle acknowledge. Each toggle passes through a two-flop synchronizer. From an accepted write until the acknowledge returns, `busy` is high and any further write is dropped. Software should poll `busy` before it writes again. The write port is a plain strobe. It has no ready signal and applies no back-pressure: a write that arrives while `busy` is high is simply lost.

A tick prescaler runs freely from reset. For that reason the reaction time of a code `n` is only known to within one tick period. It lies between `n` and `n+1` tick periods. A trip stays set after the fault goes away, and it is cleared by the `trip_clr` level input.

Top module: `fault_delay_timer`

## Requirements
- R1: After reset, `busy` and both trips are low. `oc_delay` reads 0x01 and `sc_delay` reads 0x10, and these reset codes are already in effect in the slow domain.
- R2: `wr_sel`=0 selects the over-current code, which takes `wr_data[5:0]`. `wr_sel`=1 selects the short-circuit code, which takes `wr_data[6:0]`. `oc_delay[7:6]` always reads zero.
- R3: A write with `wr_en` high while `busy` is low updates the selected code at that CPU edge, and `busy` is high in the following cycle.
- R4: A write presented while `busy` is high is dropped, and both codes keep their values.
- R5: Once raised, `busy` stays high for at least two slow-clock periods. It falls no later than three slow periods plus three CPU cycles after the accepted write.
- R6: With `fault_oc` held high and code `n`, `trip_oc` rises on the (n+1)-th over-current tick after the fault is asserted. The over-current tick comes every `OC_DIV` slow cycles, counted from reset.
- R7: The short-circuit channel behaves the same way with its own code, and its tick comes every `SC_DIV` slow cycles. This holds up to the maximum code 0x7F.
- R8: If the fault drops before the trip, the progress is discarded and no trip occurs. When the fault is raised again, the full delay starts over.
- R9: A trip stays high after its fault deasserts. It is cleared once `trip_clr` has passed through two slow-clock stages, and it stays low while `trip_clr` is held high.
- R10: Code 0 trips on the first tick after the fault is asserted.
- R11: Tick pulses are single slow-clock cycles spaced exactly by their division ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock |
| rst_cpu_n | input | 1 | Asynchronous active-low reset, CPU domain |
| clk_slow | input | 1 | Slow low-power oscillator clock |
| rst_slow_n | input | 1 | Asynchronous active-low reset, slow domain |
| wr_en | input | 1 | Write strobe for one CPU cycle |
| wr_sel | input | 1 | Write target: 0 over-current, 1 short-circuit |
| wr_data | input | 8 | Write data |
| oc_delay | output | 8 | Over-current code read-back, bits 7:6 zero |
| sc_delay | output | 7 | Short-circuit code read-back |
| busy | output | 1 | Transfer guard active; writes are dropped |
| fault_oc | input | 1 | Over-current fault, slow domain |
| fault_sc | input | 1 | Short-circuit fault, slow domain |
| trip_clr | input | 1 | Level that clears and holds off both trips |
| trip_oc | output | 1 | Latched over-current trip, slow domain |
| trip_sc | output | 1 | Latched short-circuit trip, slow domain |

## Verification
The bench writes twice back-to-back. A design that let the second write through during the guard window would show the wrong code on read-back. It measures the trip latency at code 0, at the reset codes, at mid-range codes and at the short-circuit maximum of 0x7F. An off-by-one compare would trip one tick early or late, and a counter that is too narrow would wrap and never trip. It also drops a fault halfway through the delay and then raises it again. A counter that is not cleared would trip early on the second attempt. Finally it releases a fault after a trip and holds `trip_clr` during a fault, which exposes a trip that does not latch or a clear that does not hold.

// File: rtl/fdt_pkg.sv
`timescale 1ns/1ps
package fdt_pkg;
  typedef enum logic {
    SEL_OC = 1'b0,
    SEL_SC = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fdt_sync2.sv
`timescale 1ns/1ps
module fdt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fdt_cpu_regs.sv
`timescale 1ns/1ps
module fdt_cpu_regs
  import fdt_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int OC_W   = 6,
  parameter int SC_W   = 7,
  parameter int OC_RST = 1,
  parameter int SC_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_s_i,
  output logic [OC_W-1:0]  oc_code_o,
  output logic [SC_W-1:0]  sc_code_o,
  output logic             req_o,
  output logic             busy_o
);
  logic [OC_W-1:0] oc_q;
  logic [SC_W-1:0] sc_q;
  logic            req_q;
  logic            accept;
  reg_sel_e        sel;
  logic            unused_hi;

  assign sel       = reg_sel_e'(wr_sel_i);
  assign busy_o    = req_q ^ ack_s_i;
  assign accept    = wr_en_i & ~busy_o;
  assign unused_hi = ^wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q  <= OC_W'(OC_RST);
      sc_q  <= SC_W'(SC_RST);
      req_q <= 1'b0;
    end else if (accept) begin
      req_q <= ~req_q;
      if (sel == SEL_OC) oc_q <= wr_data_i[OC_W-1:0];
      else               sc_q <= wr_data_i[SC_W-1:0];
    end
  end

  assign oc_code_o = oc_q;
  assign sc_code_o = sc_q;
  assign req_o     = req_q;

  // R3: an accepted write opens the guard window
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !busy_o) |=> busy_o);

  // R4: writes inside the guard window leave both codes untouched
  p_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && busy_o) |=> ($stable(oc_q) && $stable(sc_q)));
endmodule

// File: rtl/fdt_slow_xfer.sv
`timescale 1ns/1ps
module fdt_slow_xfer #(
  parameter int OC_W   = 6,
  parameter int SC_W   = 7,
  parameter int OC_RST = 1,
  parameter int SC_RST = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_s_i,
  input  logic [OC_W-1:0] oc_in_i,
  input  logic [SC_W-1:0] sc_in_i,
  output logic [OC_W-1:0] oc_eff_o,
  output logic [SC_W-1:0] sc_eff_o,
  output logic            ack_o
);
  logic [OC_W-1:0] oc_eff_q;
  logic [SC_W-1:0] sc_eff_q;
  logic            ack_q;

  // The CPU codes are held still while the request is outstanding,
  // so the shadow copy samples them without a multi-bit hazard.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_eff_q <= OC_W'(OC_RST);
      sc_eff_q <= SC_W'(SC_RST);
      ack_q    <= 1'b0;
    end else if (req_s_i != ack_q) begin
      oc_eff_q <= oc_in_i;
      sc_eff_q <= sc_in_i;
      ack_q    <= req_s_i;
    end
  end

  assign oc_eff_o = oc_eff_q;
  assign sc_eff_o = sc_eff_q;
  assign ack_o    = ack_q;

  // R5: the acknowledge only moves in answer to a pending request
  p_ack_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_q) |-> ($past(req_s_i) != $past(ack_q)));

  // R5: with no request pending the effective codes hold
  p_eff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s_i == ack_q) |=> ($stable(oc_eff_q) && $stable(sc_eff_q)));
endmodule

// File: rtl/fdt_tick.sv
`timescale 1ns/1ps
module fdt_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // R11: a tick lasts one slow cycle
  p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/fdt_fault_timer.sv
`timescale 1ns/1ps
module fdt_fault_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         fault_i,
  input  logic         clr_i,
  input  logic [W-1:0] code_i,
  output logic         trip_o
);
  logic [W-1:0] cnt_q;
  logic         trip_q;
  logic         due;

  assign due = tick_i && (cnt_q >= code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!fault_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q < code_i) cnt_q <= cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              trip_q <= 1'b0;
    else if (clr_i)          trip_q <= 1'b0;
    else if (fault_i && due) trip_q <= 1'b1;
  end

  assign trip_o = trip_q;

  // R6: a trip is only raised while the fault is present
  p_trip_needs_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(fault_i));

  // R8: with the fault absent no new trip appears
  p_idle_no_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && !trip_q) |=> !trip_q);

  // R9: trip latches until cleared
  p_trip_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clr_i) |=> trip_q);

  // R9: clear wins
  p_clr_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !trip_q);
endmodule

// File: rtl/fault_delay_timer.sv
`timescale 1ns/1ps
module fault_delay_timer #(
  parameter int REG_W  = 8,
  parameter int OC_W   = 6,
  parameter int SC_W   = 7,
  parameter int OC_RST = 1,
  parameter int SC_RST = 16,
  parameter int OC_DIV = 64,
  parameter int SC_DIV = 8
) (
  input  logic             clk_cpu,
  input  logic             rst_cpu_n,
  input  logic             clk_slow,
  input  logic             rst_slow_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] oc_delay,
  output logic [SC_W-1:0]  sc_delay,
  output logic             busy,
  input  logic             fault_oc,
  input  logic             fault_sc,
  input  logic             trip_clr,
  output logic             trip_oc,
  output logic             trip_sc
);
  logic [OC_W-1:0] oc_code, oc_eff;
  logic [SC_W-1:0] sc_code, sc_eff;
  logic            req, req_s, ack, ack_s, clr_s;
  logic            tick_oc, tick_sc;

  fdt_cpu_regs #(
    .REG_W(REG_W), .OC_W(OC_W), .SC_W(SC_W), .OC_RST(OC_RST), .SC_RST(SC_RST)
  ) u_regs (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ack_s_i(ack_s), .oc_code_o(oc_code),
    .sc_code_o(sc_code), .req_o(req), .busy_o(busy)
  );

  fdt_sync2 #(.W(1)) u_ack_sync (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .d_i(ack), .q_o(ack_s)
  );

  fdt_sync2 #(.W(1)) u_req_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .d_i(req), .q_o(req_s)
  );

  fdt_sync2 #(.W(1)) u_clr_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .d_i(trip_clr), .q_o(clr_s)
  );

  fdt_slow_xfer #(
    .OC_W(OC_W), .SC_W(SC_W), .OC_RST(OC_RST), .SC_RST(SC_RST)
  ) u_xfer (
    .clk(clk_slow), .rst_n(rst_slow_n), .req_s_i(req_s),
    .oc_in_i(oc_code), .sc_in_i(sc_code),
    .oc_eff_o(oc_eff), .sc_eff_o(sc_eff), .ack_o(ack)
  );

  fdt_tick #(.DIV(OC_DIV)) u_tick_oc (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick_o(tick_oc)
  );

  fdt_tick #(.DIV(SC_DIV)) u_tick_sc (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick_o(tick_sc)
  );

  fdt_fault_timer #(.W(OC_W)) u_tmr_oc (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick_i(tick_oc), .fault_i(fault_oc),
    .clr_i(clr_s), .code_i(oc_eff), .trip_o(trip_oc)
  );

  fdt_fault_timer #(.W(SC_W)) u_tmr_sc (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick_i(tick_sc), .fault_i(fault_sc),
    .clr_i(clr_s), .code_i(sc_eff), .trip_o(trip_sc)
  );

  assign oc_delay = REG_W'(oc_code);
  assign sc_delay = sc_code;
endmodule

// File: tb/fault_delay_timer_tb.sv
`timescale 1ns/1ps
module fault_delay_timer_tb;
  localparam int OC_DIV = 8;
  localparam int SC_DIV = 2;

  logic       clk_cpu = 1'b0, clk_slow = 1'b0;
  logic       rst_cpu_n = 1'b0, rst_slow_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] oc_delay;
  logic [6:0] sc_delay;
  logic       busy, trip_oc, trip_sc;
  logic       fault_oc = 1'b0, fault_sc = 1'b0, trip_clr = 1'b0;

  always #5  clk_cpu  = ~clk_cpu;
  always #36 clk_slow = ~clk_slow;

  fault_delay_timer #(.OC_DIV(OC_DIV), .SC_DIV(SC_DIV)) u_dut (
    .clk_cpu(clk_cpu), .rst_cpu_n(rst_cpu_n), .clk_slow(clk_slow),
    .rst_slow_n(rst_slow_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .oc_delay(oc_delay), .sc_delay(sc_delay), .busy(busy),
    .fault_oc(fault_oc), .fault_sc(fault_sc), .trip_clr(trip_clr),
    .trip_oc(trip_oc), .trip_sc(trip_sc)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model, CPU side ----------------
  int m_oc = 1, m_sc = 16;
  bit busy_neg = 1'b0, acc_evt = 1'b0;
  int bcount = 0, bwindows = 0;

  always @(posedge clk_cpu) begin
    if (rst_cpu_n && wr_en && !busy_neg) begin
      acc_evt = 1'b1;
      if (!wr_sel) m_oc = wr_data & 8'h3F;
      else         m_sc = wr_data & 8'h7F;
    end
  end

  always @(negedge clk_cpu) begin
    if (rst_cpu_n) begin
      check(oc_delay == 8'(m_oc), "R3", "oc_delay readback", oc_delay, m_oc);
      check(sc_delay == 7'(m_sc), "R3", "sc_delay readback", sc_delay, m_sc);
      if (acc_evt) check(busy == 1'b1, "R3", "busy after write", busy, 1);
      acc_evt = 1'b0;
      if (busy) bcount++;
      else if (bcount > 0) begin
        check(bcount >= 14 && bcount <= 25, "R5", "busy window cycles", bcount, 20);
        bwindows++;
        bcount = 0;
      end
    end
    busy_neg = busy;
  end

  // ---------------- reference model, slow side ----------------
  int k = 0, cnt_oc = 0, cnt_sc = 0;
  bit m_trip_oc = 1'b0, m_trip_sc = 1'b0, clr_h1 = 1'b0, clr_h2 = 1'b0;

  always @(posedge clk_slow) begin
    if (rst_slow_n) begin
      bit t_oc, t_sc, ce;
      k++;
      t_oc = ((k - 1) % OC_DIV) == OC_DIV - 1;
      t_sc = ((k - 1) % SC_DIV) == SC_DIV - 1;
      ce = clr_h2;
      clr_h2 = clr_h1;
      clr_h1 = trip_clr;
      if (ce) m_trip_oc = 1'b0;
      else if (fault_oc && t_oc && cnt_oc >= m_oc) m_trip_oc = 1'b1;
      if (ce) m_trip_sc = 1'b0;
      else if (fault_sc && t_sc && cnt_sc >= m_sc) m_trip_sc = 1'b1;
      if (!fault_oc) cnt_oc = 0; else if (t_oc && cnt_oc < m_oc) cnt_oc++;
      if (!fault_sc) cnt_sc = 0; else if (t_sc && cnt_sc < m_sc) cnt_sc++;
    end
  end

  always @(negedge clk_slow) begin
    if (rst_slow_n) begin
      check(trip_oc == m_trip_oc, "R6", "trip_oc vs model", trip_oc, m_trip_oc);
      check(trip_sc == m_trip_sc, "R7", "trip_sc vs model", trip_sc, m_trip_sc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cpu_write(input bit sel, input logic [7:0] d);
    @(negedge clk_cpu); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk_cpu); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_cpu);
    while (busy) @(negedge clk_cpu);
    repeat (2) @(negedge clk_cpu);
  endtask

  task automatic measure(input bit is_sc, output int n);
    @(negedge clk_slow);
    if (is_sc) fault_sc = 1'b1; else fault_oc = 1'b1;
    n = 0;
    do begin
      @(negedge clk_slow);
      n++;
    end while (!(is_sc ? trip_sc : trip_oc) && n < 5000);
  endtask

  task automatic release_and_clear(input string req);
    @(negedge clk_slow); fault_oc = 1'b0; fault_sc = 1'b0;
    repeat (10) @(negedge clk_slow);
    check(trip_oc || trip_sc, req, "trip held after fault drop", int'(trip_oc | trip_sc), 1);
    trip_clr = 1'b1;
    repeat (4) @(negedge clk_slow);
    check(!trip_oc && !trip_sc, "R9", "trips cleared", int'(trip_oc | trip_sc), 0);
    trip_clr = 1'b0;
    repeat (3) @(negedge clk_slow);
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int n;
    #200;
    @(negedge clk_slow);
    rst_cpu_n = 1'b1; rst_slow_n = 1'b1;
    @(negedge clk_cpu);
    // R1: reset state
    check(oc_delay == 8'h01, "R1", "oc_delay reset", oc_delay, 1);
    check(sc_delay == 7'h10, "R1", "sc_delay reset", sc_delay, 16);
    check(busy == 1'b0, "R1", "busy reset", busy, 0);
    check(!trip_oc && !trip_sc, "R1", "trips reset", int'(trip_oc | trip_sc), 0);

    // R1: reset codes already in effect
    measure(1'b0, n);
    check(n >= OC_DIV + 1 && n <= 2 * OC_DIV, "R1", "oc latency reset code", n, 2 * OC_DIV);
    release_and_clear("R9");
    measure(1'b1, n);
    check(n >= 16 * SC_DIV + 1 && n <= 17 * SC_DIV, "R1", "sc latency reset code", n, 17 * SC_DIV);
    release_and_clear("R9");

    // R2 + R4: masked write, second back-to-back write dropped
    @(negedge clk_cpu); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hCA;
    @(negedge clk_cpu); wr_data = 8'h20;
    @(negedge clk_cpu); wr_en = 1'b0;
    check(oc_delay == 8'h0A, "R4", "oc code during guard", oc_delay, 10);
    wait_idle();
    check(oc_delay == 8'h0A, "R2", "oc reserved bits zero", oc_delay, 10);
    check(oc_delay == 8'h0A, "R4", "dropped write left code", oc_delay, 10);
    cpu_write(1'b1, 8'h85);
    wait_idle();
    check(sc_delay == 7'h05, "R2", "sc code width", sc_delay, 5);
    check(bwindows >= 2, "R5", "guard windows observed", bwindows, 2);

    // R6: over-current delay at code 10
    measure(1'b0, n);
    check(n >= 10 * OC_DIV + 1 && n <= 11 * OC_DIV, "R6", "oc latency code 10", n, 11 * OC_DIV);
    release_and_clear("R9");

    // R8: interrupted fault restarts the delay
    @(negedge clk_slow); fault_oc = 1'b1;
    repeat (6 * OC_DIV) @(negedge clk_slow);
    check(!trip_oc, "R8", "no trip before delay", trip_oc, 0);
    fault_oc = 1'b0;
    repeat (5) @(negedge clk_slow);
    check(!trip_oc, "R8", "no trip after drop", trip_oc, 0);
    measure(1'b0, n);
    check(n >= 10 * OC_DIV + 1 && n <= 11 * OC_DIV, "R8", "full delay after restart", n, 11 * OC_DIV);
    release_and_clear("R9");

    // R7: short-circuit code 5
    measure(1'b1, n);
    check(n >= 5 * SC_DIV + 1 && n <= 6 * SC_DIV, "R7", "sc latency code 5", n, 6 * SC_DIV);
    release_and_clear("R9");

    // R10: code 0
    cpu_write(1'b0, 8'h00);
    wait_idle();
    measure(1'b0, n);
    check(n >= 1 && n <= OC_DIV, "R10", "oc latency code 0", n, OC_DIV);
    release_and_clear("R9");

    // R7: short-circuit maximum code
    cpu_write(1'b1, 8'h7F);
    wait_idle();
    check(sc_delay == 7'h7F, "R7", "sc max code", sc_delay, 127);
    measure(1'b1, n);
    check(n >= 127 * SC_DIV + 1 && n <= 128 * SC_DIV, "R7", "sc latency max code", n, 128 * SC_DIV);
    release_and_clear("R9");

    // R9: clear held during fault blocks trip
    @(negedge clk_slow); trip_clr = 1'b1;
    repeat (3) @(negedge clk_slow);
    fault_oc = 1'b1;
    repeat (3 * OC_DIV) @(negedge clk_slow);
    check(!trip_oc, "R9", "trip held off by clear", trip_oc, 0);
    trip_clr = 1'b0;
    repeat (OC_DIV + 4) @(negedge clk_slow);
    check(trip_oc, "R9", "trip after clear release", trip_oc, 1);
    fault_oc = 1'b0;
    // R11: tick spacing is covered by the per-cycle model comparison
    repeat (4) @(negedge clk_slow);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule